// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose data bus can swap between read and write on every clock with no idle cycle. Commands (address, write enable, byte strobes, chip selects, burst advance) are captured on the rising clock edge. Write data follows its command later, so a write's data slot lines up with the slot a read at the same point would use. In pipeline mode write data follows by two active edges. In flow-through mode it follows by one. Read data leaves through an extra output register in pipeline mode and straight from the array in flow-through mode.

A 2-bit burst counter is loaded from the two low address bits when an access opens. While the advance input is high the counter steps instead of loading a new address, in linear or interleaved order. An active-low clock enable freezes the whole block for a cycle. An asynchronous output enable and a sleep input force the data drive off. The bus is presented as a data input, a data output and a drive-enable output that an external pad ring turns into a tristate pin.

Top module: `zt_sram`

## Requirements
- R1: In flow-through mode (`flow_thru`=1), a read sampled at an active edge drives `dq_out` with the word at that address, and `dq_oe` high, from that edge until the next active edge.
- R2: In pipeline mode (`flow_thru`=0), read data and `dq_oe` appear one active edge later than in flow-through mode.
- R3: Write data on `dq_in` is taken at the first active edge after the write command in flow-through mode, and at the second in pipeline mode.
- R4: Reads and writes may alternate on every cycle with no idle cycle. A read issued right after a write to the same address returns the newly written data in both modes.
- R5: A new access is opened only when `burst_adv`=0 and `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at once. Any other combination with `burst_adv`=0 is a deselect: it performs no access and closes any open burst.
- R6: An edge with `clk_en_n`=1 changes nothing: no command is taken, no write completes, no counter steps and the outputs keep their values.
- R7: The data word is split into 9-bit lanes, lane l being bits [9l+8:9l]. Lane l of a write is stored only when `lane_wr_n[l]`=0, and the strobes are sampled with the command.
- R8: `out_en_n`=1 forces `dq_oe` low at once, without a clock edge, and leaves the read pipeline untouched, so the drive returns as soon as it goes low again.
- R9: With `burst_adv`=1 and an open burst, the next beat uses the same upper address bits. With `burst_ileave`=0 its 2-bit offset is (start + k) mod 4, where k counts beats since the opening access and wraps after 3.
- R10: With `burst_ileave`=1 the beat offset is start XOR k.
- R11: A burst beat keeps the read or write type of the opening access, ignoring `wr_n` and the chip selects. Each write beat stores data at its own beat address. `burst_adv`=1 with no open burst performs no access.
- R12: `sleep`=1 blocks new accesses and burst beats, closes any open burst and holds `dq_oe` low. Accesses already in flight still complete, stored data is kept, and operation resumes when `sleep` returns low.
- R13: While `rst_n` is low, `dq_oe` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en_n | input | 1 | Active-low clock enable; high holds the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low; high means read |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| burst_adv | input | 1 | High steps the open burst instead of loading an address |
| burst_ileave | input | 1 | Burst order: 0 linear, 1 interleaved |
| flow_thru | input | 1 | 1 selects flow-through timing, 0 selects pipeline timing |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address; the two low bits seed the burst counter |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data toward the bus |
| dq_oe | output | 1 | Bus drive enable for `dq_out` |

## Verification
On every cycle the assertions check that the hold freezes the burst counter and the command pipeline, that the burst offset wraps after four beats, that a deselect or sleep closes the burst, that no access starts without all three selects, that sleep admits no command, that a pipeline write moves from the first stage into the second, and that flow-through reads never share a beat with a write. The data values themselves can only be shown by the bench's scenarios. A behavioural model, driven by the same pins, compares the drive enable and read data after every edge. It covers the two latencies, read-after-write in both modes, lane masking, both burst orders with wrap, burst type inheritance, holds within bursts and write slots, and sleep and output enable arriving in mid-stream.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

   // Burst offset width: the counter covers four beats.
   localparam int OFF_W = 2;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

   // Offset of beat k of a burst that opened at offset start.
   function automatic logic [OFF_W-1:0] beat_offset(input logic [OFF_W-1:0] start,
                                                    input logic [OFF_W-1:0] step,
                                                    input logic             ileave);
      logic [OFF_W-1:0] res;
      if (ileave) res = start ^ step;
      else        res = start + step;
      return res;
   endfunction

endpackage

// File: rtl/zt_burst_seq.sv
`timescale 1ns/1ps
module zt_burst_seq
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              sel_ok,
   input  logic              sleep,
   input  logic              adv,
   input  logic              wr_n,
   input  logic              ileave,
   input  logic [ADDR_W-1:0] addr,
   output op_e               cmd_op,
   output logic [ADDR_W-1:0] cmd_addr
);
   localparam int BASE_W = ADDR_W - OFF_W;

   op_e               open_q;
   logic [BASE_W-1:0] base_q;
   logic [OFF_W-1:0]  start_q;
   logic [OFF_W-1:0]  step_q;
   logic [OFF_W-1:0]  step_nx;
   logic              cont;
   logic              fresh;

   assign step_nx = step_q + 1'b1;
   assign cont    = adv && !sleep && (open_q != OP_NONE);
   assign fresh   = !adv && sel_ok;

   // Command seen at this edge: a burst beat, a new access, or nothing.
   always_comb begin
      cmd_op   = OP_NONE;
      cmd_addr = addr;
      if (cont) begin
         cmd_op   = open_q;
         cmd_addr = {base_q, beat_offset(start_q, step_nx, ileave)};
      end else if (fresh) begin
         cmd_op   = wr_n ? OP_RD : OP_WR;
         cmd_addr = addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= OP_NONE;
         base_q  <= '0;
         start_q <= '0;
         step_q  <= '0;
      end else if (!hold) begin
         if (cont) begin
            step_q <= step_nx;
         end else if (fresh) begin
            open_q  <= wr_n ? OP_RD : OP_WR;
            base_q  <= addr[ADDR_W-1:OFF_W];
            start_q <= addr[OFF_W-1:0];
            step_q  <= '0;
         end else begin
            open_q <= OP_NONE;
         end
      end
   end

   AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(open_q) && $stable(step_q) && $stable(base_q)); // R6

   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && cont && step_q == 2'd3) |=> (step_q == 2'd0)); // R9

   AST_DESEL_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !adv && !sel_ok) |=> (open_q == OP_NONE)); // R5

   AST_SLEEP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && sleep) |=> (open_q == OP_NONE)); // R12

endmodule

// File: rtl/zt_cmd_pipe.sv
`timescale 1ns/1ps
module zt_cmd_pipe
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              flow,
   input  op_e               cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LANES-1:0]  cmd_be_n,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LANES-1:0]  wr_be_n,
   output logic              rd_now,
   output logic [ADDR_W-1:0] rd_addr
);
   // Stage 0 holds the command of the last edge, stage 1 the one before.
   localparam int NSTG = 2;

   op_e               st_op   [NSTG];
   logic [ADDR_W-1:0] st_addr [NSTG];
   logic [LANES-1:0]  st_be   [NSTG];
   logic              wsel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSTG; i++) begin
            st_op[i]   <= OP_NONE;
            st_addr[i] <= '0;
            st_be[i]   <= '1;
         end
      end else if (!hold) begin
         st_op[0]   <= cmd_op;
         st_addr[0] <= cmd_addr;
         st_be[0]   <= cmd_be_n;
         for (int i = 1; i < NSTG; i++) begin
            st_op[i]   <= st_op[i-1];
            st_addr[i] <= st_addr[i-1];
            st_be[i]   <= st_be[i-1];
         end
      end
   end

   // Single late write commits from stage 0, double late write from stage 1.
   assign wsel    = !flow;
   assign wr_en   = !hold && (st_op[wsel] == OP_WR);
   assign wr_addr = st_addr[wsel];
   assign wr_be_n = st_be[wsel];
   assign rd_now  = (st_op[0] == OP_RD);
   assign rd_addr = st_addr[0];

   AST_HOLD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(st_op[0]) && $stable(st_op[1]) && $stable(st_addr[1])); // R6

   AST_LATE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !flow && st_op[0] == OP_WR) |=> (st_op[1] == OP_WR)); // R3

endmodule

// File: rtl/zt_mem_array.sv
`timescale 1ns/1ps
module zt_mem_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES-1:0]        wbe_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && !wbe_n[l]) cells[waddr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
   end

endmodule

// File: rtl/zt_rd_path.sv
`timescale 1ns/1ps
module zt_rd_path #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  logic                    flow,
   input  logic                    rd_now,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [LANES*LANE_W-1:0] arr_data,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_be_n,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic                    out_valid,
   output logic [LANES*LANE_W-1:0] out_data
);
   localparam int DATA_W = LANES * LANE_W;

   logic              hit;
   logic [DATA_W-1:0] merged;
   logic              q_valid;
   logic [DATA_W-1:0] q_data;

   // A write landing on the same edge as the output load is forwarded lane by lane.
   assign hit = wr_en && (wr_addr == rd_addr);

   for (genvar l = 0; l < LANES; l++) begin : g_fwd
      assign merged[l*LANE_W +: LANE_W] = (hit && !wr_be_n[l]) ?
                                          wr_data[l*LANE_W +: LANE_W] :
                                          arr_data[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_data  <= '0;
      end else if (!hold) begin
         q_valid <= rd_now;
         q_data  <= merged;
      end
   end

   assign out_valid = flow ? rd_now   : q_valid;
   assign out_data  = flow ? arr_data : q_data;

   AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q_valid) && $stable(q_data)); // R6

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    burst_adv,
   input  logic                    burst_ileave,
   input  logic                    flow_thru,
   input  logic                    out_en_n,
   input  logic                    sleep,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < OFF_W + 1) begin : g_bad_addr
      $error("zt_sram: ADDR_W must leave at least one bit above the burst offset");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("zt_sram: LANES and LANE_W must be positive");
   end
   if (ADDR_W > 16) begin : g_bad_depth
      $error("zt_sram: ADDR_W above 16 gives an oversized model array");
   end

   logic              hold;
   logic              sel_ok;
   op_e               cmd_op;
   logic [ADDR_W-1:0] cmd_addr;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [LANES-1:0]  wr_be_n;
   logic              rd_now;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] arr_data;
   logic              out_valid;

   assign hold   = clk_en_n;
   assign sel_ok = !sel_a_n && sel_b && !sel_c_n && !sleep;

   zt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .sel_ok   (sel_ok),
      .sleep    (sleep),
      .adv      (burst_adv),
      .wr_n     (wr_n),
      .ileave   (burst_ileave),
      .addr     (addr),
      .cmd_op   (cmd_op),
      .cmd_addr (cmd_addr)
   );

   zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .flow     (flow_thru),
      .cmd_op   (cmd_op),
      .cmd_addr (cmd_addr),
      .cmd_be_n (lane_wr_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_be_n  (wr_be_n),
      .rd_now   (rd_now),
      .rd_addr  (rd_addr)
   );

   zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wbe_n (wr_be_n),
      .wdata (dq_in),
      .raddr (rd_addr),
      .rdata (arr_data)
   );

   zt_rd_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (hold),
      .flow      (flow_thru),
      .rd_now    (rd_now),
      .rd_addr   (rd_addr),
      .arr_data  (arr_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_be_n   (wr_be_n),
      .wr_data   (dq_in),
      .out_valid (out_valid),
      .out_data  (dq_out)
   );

   assign dq_oe = out_valid && !out_en_n && !sleep;

   AST_SEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op != OP_NONE && !burst_adv) |-> (!sel_a_n && sel_b && !sel_c_n)); // R5

   AST_SLEEP_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (cmd_op == OP_NONE)); // R12

   AST_FT_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_thru && dq_oe) |-> !wr_en); // R4

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> !dq_oe); // R13

endmodule

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

   localparam int AW = 8;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          sel_a_n = 1'b1;
   logic          sel_b = 1'b1;
   logic          sel_c_n = 1'b0;
   logic          wr_n = 1'b1;
   logic [NL-1:0] lane_wr_n = '1;
   logic          burst_adv = 1'b0;
   logic          burst_ileave = 1'b0;
   logic          flow_thru = 1'b1;
   logic          out_en_n = 1'b0;
   logic          sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   always #2 clk = ~clk;   // 250 MHz

   zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_zt_sram (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .burst_adv(burst_adv),
      .burst_ileave(burst_ileave), .flow_thru(flow_thru), .out_en_n(out_en_n),
      .sleep(sleep), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   // ---------------- behavioural reference model ----------------
   typedef struct {
      int            kind;   // 1 read, 2 write
      int            a;
      logic [NL-1:0] be;
      int            due;    // active edge at which it lands
   } pend_t;

   pend_t         pq[$];
   logic [DW-1:0] mm [256];
   int            ecnt = 0;
   int            b_open = 0, b_base = 0, b_start = 0, b_k = 0;
   logic          m_valid = 1'b0;
   logic [DW-1:0] m_data = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pq.delete();
         b_open  = 0;
         m_valid = 1'b0;
      end else if (!clk_en_n) begin
         int    kind, ea, off;
         pend_t keep[$];
         ecnt++;
         foreach (pq[i]) begin
            if (pq[i].kind == 2 && pq[i].due == ecnt) begin
               for (int l = 0; l < NL; l++)
                  if (!pq[i].be[l]) mm[pq[i].a][l*LW +: LW] = dq_in[l*LW +: LW];
            end
         end
         kind = 0; ea = 0;
         if (sleep) begin
            b_open = 0;
         end else if (burst_adv) begin
            if (b_open != 0) begin
               b_k  = (b_k + 1) % 4;
               off  = burst_ileave ? (b_start ^ b_k) : ((b_start + b_k) % 4);
               ea   = (b_base / 4) * 4 + off;
               kind = b_open;
            end
         end else if (!sel_a_n && sel_b && !sel_c_n) begin
            kind    = wr_n ? 1 : 2;
            ea      = int'(addr);
            b_open  = kind;
            b_base  = ea;
            b_start = ea % 4;
            b_k     = 0;
         end else begin
            b_open = 0;
         end
         if (kind != 0)
            pq.push_back('{kind: kind, a: ea, be: lane_wr_n,
                           due: ecnt + (kind == 2 ? (flow_thru ? 1 : 2) : (flow_thru ? 0 : 1))});
         m_valid = 1'b0;
         foreach (pq[i]) begin
            if (pq[i].kind == 1 && pq[i].due == ecnt) begin
               m_valid = 1'b1;
               m_data  = mm[pq[i].a];
            end
         end
         foreach (pq[i]) if (pq[i].due > ecnt) keep.push_back(pq[i]);
         pq = keep;
      end
   end

   // ---------------- checking ----------------
   int    n_chk = 0;
   int    n_err = 0;
   string cur_req = "R13";

   task automatic chk1(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic exp_oe;
      exp_oe = m_valid && !out_en_n && !sleep;
      chk1(cur_req, "dq_oe", DW'(dq_oe), DW'(exp_oe));
      if (exp_oe && dq_oe) chk1(cur_req, "dq_out", dq_out, m_data);
   endtask

   task automatic step();
      logic [63:0] rnd;
      @(posedge clk);
      #1;
      compare();
      rnd   = {$urandom(), $urandom()};
      dq_in = rnd[DW-1:0];
   endtask

   task automatic sel_on();
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
   endtask

   task automatic rd(input int a);
      sel_on(); burst_adv = 1'b0; wr_n = 1'b1; lane_wr_n = '1; addr = AW'(a);
      step();
   endtask

   task automatic wr(input int a, input logic [NL-1:0] be);
      sel_on(); burst_adv = 1'b0; wr_n = 1'b0; lane_wr_n = be; addr = AW'(a);
      step();
   endtask

   // Burst beat with selects dropped and write enable flipped, which must not matter.
   task automatic beat();
      sel_a_n = 1'b1; sel_b = 1'b0; burst_adv = 1'b1; wr_n = ~wr_n; addr = ~addr;
      lane_wr_n = 4'b0000;
      step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         sel_a_n = 1'b1; burst_adv = 1'b0; wr_n = 1'b0;
         step();
      end
   endtask

   task automatic desel_wr(input logic c1, input logic c2, input logic c3, input int a);
      sel_a_n = c1; sel_b = c2; sel_c_n = c3; burst_adv = 1'b0; wr_n = 1'b0;
      lane_wr_n = '0; addr = AW'(a);
      step();
   endtask

   task automatic hold(input int n);
      for (int i = 0; i < n; i++) begin
         clk_en_n = 1'b1; sel_on(); burst_adv = 1'b0; wr_n = 1'b0; addr = 8'hEE;
         step();
      end
      clk_en_n = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk1("R13", "dq_oe in reset", DW'(dq_oe), '0);
      rst_n = 1'b1;

      cur_req = "R3";      // fill every word, flow-through single late write
      flow_thru = 1'b1;
      for (int a = 0; a < 256; a++) wr(a, 4'b0000);
      idle(3);

      cur_req = "R1";
      rd(5); rd(17); idle(1); rd(255); rd(0); idle(3);

      flow_thru = 1'b0;
      cur_req = "R2";
      rd(5); rd(6); idle(1); rd(200); idle(3);

      cur_req = "R3";      // pipeline double late write
      wr(10, 4'b0000); wr(11, 4'b0000); idle(1); rd(10); rd(11); idle(3);

      cur_req = "R4";
      wr(20, 4'b0000); rd(20); wr(20, 4'b0000); rd(21); rd(20);
      wr(22, 4'b0000); wr(22, 4'b1100); rd(22); idle(3);

      cur_req = "R7";
      wr(30, 4'b1010); wr(31, 4'b0111); rd(30); rd(31); wr(32, 4'b1111); rd(32); idle(3);

      cur_req = "R5";
      desel_wr(1'b1, 1'b1, 1'b0, 40); desel_wr(1'b0, 1'b0, 1'b0, 41);
      desel_wr(1'b0, 1'b1, 1'b1, 42);
      rd(43); desel_wr(1'b1, 1'b0, 1'b1, 43); beat(); idle(2);
      rd(40); rd(41); rd(42); idle(3);

      cur_req = "R6";
      rd(44); hold(3); rd(45); idle(1); hold(2);
      wr(46, 4'b0000); hold(2); idle(1); hold(1); idle(2); rd(46);
      wr(47, 4'b0000); rd(48); hold(2); beat(); idle(3);

      cur_req = "R8";
      rd(50); out_en_n = 1'b1; #1;
      chk1("R8", "dq_oe async off", DW'(dq_oe), '0);
      rd(51); rd(52);
      out_en_n = 1'b0; #1;
      chk1("R8", "dq_oe async on", DW'(dq_oe), DW'(m_valid));
      idle(3);

      cur_req = "R9";
      burst_ileave = 1'b0;
      rd(56); beat(); beat(); beat(); beat(); beat();
      rd(71); beat(); beat(); beat(); idle(3);

      cur_req = "R10";
      burst_ileave = 1'b1;
      rd(62); beat(); beat(); beat();
      wr(97, 4'b0000); beat(); beat(); beat(); idle(2);
      rd(96); rd(97); rd(98); rd(99); idle(3);

      cur_req = "R11";
      burst_ileave = 1'b0;
      wr(129, 4'b0000); beat(); beat(); idle(2);
      rd(128); rd(129); rd(130); rd(131);
      idle(2); beat(); beat(); idle(1); rd(129); beat(); idle(3);

      cur_req = "R12";
      rd(88); beat(); sleep = 1'b1; #1;
      chk1("R12", "dq_oe under sleep", DW'(dq_oe), '0);
      beat(); wr(89, 4'b0000); sleep = 1'b0; beat(); idle(2);
      wr(90, 4'b0000); sleep = 1'b1; idle(3); sleep = 1'b0; idle(1);
      rd(89); rd(90); rd(88); idle(3);

      flow_thru = 1'b1;
      cur_req = "R4";
      wr(100, 4'b0000); rd(100); wr(101, 4'b0110); rd(101); rd(100); wr(100, 4'b0000);
      rd(100); idle(3);

      cur_req = "R1";
      rd(104); beat(); beat(); beat(); hold(2); idle(3);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule